// File: doc/BRIEF.md
# I2C Target Register Access Controller

This block is a 7-bit-addressed I2C target that gives a bus controller access to a small bank of 8-bit registers. SCL and SDA are brought into the system clock domain through a short flop chain. Edge and condition detection then runs on those synchronised levels. The block drives SDA only through an open-drain enable: when `sda_oe` is high, the line is pulled low. The pad and the bus pull-up are outside the block.

Two transfer shapes are served. In a write, the controller sends the target address with the direction bit clear, then a register index, then one data byte. In a read, the controller sends the address with the write direction and the register index, issues a repeated START, sends the address again with the read direction, and clocks one byte out of the target. The index latched during the write phase selects the register for the read. A parameter mask says which indices exist. An index outside that map is refused with a NACK, and the rest of the transfer is then ignored.

Top module: `i2c_tgt_regbank`

## Requirements
- R1: SDA falling while SCL is high is a START. It is recognised at any bit position, including part-way through a byte. It clears the bit counter and restarts reception with the address byte.
- R2: SDA rising while SCL is high is a STOP. It returns the block to idle, releases SDA, and forgets the latched register index, so a read-direction address after a new START is NACKed.
- R3: The first byte after a START carries the 7-bit target address, MSB first, followed by a direction bit (0 = write, 1 = read). If the address differs from `TGT_ADDR`, SDA stays released for the acknowledge pulse and for every pulse up to the next START or STOP. No register changes.
- R4: The byte after a matching write-direction address is a register index. The index is defined when it is below `NUM_REGS` and bit `index` of `DEFINED_MASK` is 1. A defined index is ACKed and latched. An undefined index is NACKed, any following data byte is also NACKed, and no register changes.
- R5: A data byte after an accepted index is written into that register once its 8th bit has been sampled, and the byte is then ACKed. Any further byte in the same transfer is NACKed and is written nowhere, so no auto-increment takes place.
- R6: A read-direction address after a repeated START is ACKed only if a defined index was latched earlier in the same transfer. If one was, the target then sends that register's value MSB first. If none was, the address is NACKed.
- R7: The target releases SDA for the acknowledge pulse that follows the read data byte. It drives nothing more until the next START.
- R8: The target starts pulling SDA low only while SCL is low. An ACK keeps SDA low for the whole high period of the 9th SCL pulse.
- R9: After reset, SDA is released and register i holds (37*i + 90) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level as seen at the pad |
| sda_i | input | 1 | Bus data level as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bound checker watches the bus-timing rules on every cycle. These are: a new pull-down begins only with SCL low, a pull-down is held through a high SCL period, START clears the counter, and STOP drops to a quiet idle. The checker also requires that a register write happens only to a defined index and directly after the 8th sampled bit. Whether the right byte is ACKed, whether refused transfers leave the registers unchanged, and whether read data matches earlier writes can only be shown by the bench scenarios. Those scenarios sweep every index inside and just beyond the map, corrupt each address bit, and cut transfers with early STOPs and mid-byte repeated STARTs.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_REG   = 3'd2,
    PH_WDATA = 3'd3,
    PH_RDATA = 3'd4,
    PH_SKIP  = 3'd5
  } phase_t;

  localparam int unsigned MAP_SPAN = 256;

  // Power-on contents of register idx.
  function automatic logic [7:0] reg_reset_value(input int unsigned idx);
    return 8'((idx * 37 + 90) % 256);
  endfunction

  // An index exists when it lies inside the bank and its mask bit is set.
  function automatic logic reg_defined(input logic [MAP_SPAN-1:0] mask,
                                       input int unsigned count,
                                       input logic [7:0] idx);
    return (32'(idx) < count) && mask[idx];
  endfunction

  // Upper seven bits of the first byte compared with the own address.
  function automatic logic addr_match(input logic [7:0] first_byte,
                                      input logic [6:0] own);
    return first_byte[7:1] == own;
  endfunction

endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned           NUM_REGS     = 16,
  parameter logic [NUM_REGS-1:0]   DEFINED_MASK = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] waddr,
  input  logic [7:0] wdata,
  input  logic [7:0] raddr,
  output logic [7:0] rdata
);

  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0] rd_word [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    if (DEFINED_MASK[i]) begin : g_store
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= reg_reset_value(i);
        else if (we && (32'(waddr) == i))
          q <= wdata;
      end
      assign rd_word[i] = q;
    end else begin : g_hole
      assign rd_word[i] = 8'h00;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (32'(raddr) < NUM_REGS)
      rdata = rd_word[raddr[IDX_W-1:0]];
  end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]          TGT_ADDR     = 7'h2A,
  parameter int unsigned         NUM_REGS     = 16,
  parameter logic [NUM_REGS-1:0] DEFINED_MASK = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       reg_we,
  output logic [7:0] reg_waddr,
  output logic [7:0] reg_wdata,
  output phase_t     phase,
  output logic [3:0] bit_cnt
);

  localparam logic [MAP_SPAN-1:0] MASK_EXT = MAP_SPAN'(DEFINED_MASK);
  localparam logic [3:0]          ACK_SLOT = 4'd8;
  localparam logic [3:0]          LAST_BIT = 4'd7;

  logic [7:0] shreg;
  logic [7:0] tx_byte;
  logic [7:0] ptr;
  logic       ptr_ok;
  logic       ack_go;
  phase_t     after_phase;

  logic [7:0] byte_in;
  logic       dec_ack;
  phase_t     dec_next;
  logic       dec_latch;
  logic       dec_forget;
  logic       dec_write;
  logic       listening;
  logic [2:0] bit_sel;
  logic       slot_drive;

  assign byte_in   = {shreg[6:0], sda_lvl};
  assign listening = (phase == PH_ADDR) || (phase == PH_REG) ||
                     (phase == PH_WDATA) || (phase == PH_RDATA);
  assign bit_sel   = 3'd7 - bit_cnt[2:0];

  // What to answer once the 8th bit of the current byte is in.
  always_comb begin
    dec_ack    = 1'b0;
    dec_next   = PH_SKIP;
    dec_latch  = 1'b0;
    dec_forget = 1'b0;
    dec_write  = 1'b0;
    unique case (phase)
      PH_ADDR: begin
        if (addr_match(byte_in, TGT_ADDR)) begin
          if (!byte_in[0]) begin
            dec_ack  = 1'b1;
            dec_next = PH_REG;
          end else if (ptr_ok) begin
            dec_ack  = 1'b1;
            dec_next = PH_RDATA;
          end
        end
      end
      PH_REG: begin
        if (reg_defined(MASK_EXT, NUM_REGS, byte_in)) begin
          dec_ack   = 1'b1;
          dec_next  = PH_WDATA;
          dec_latch = 1'b1;
        end else begin
          dec_forget = 1'b1;
        end
      end
      PH_WDATA: begin
        dec_ack   = 1'b1;
        dec_write = 1'b1;
      end
      default: ;
    endcase
  end

  // Level to present while SCL is next high.
  always_comb begin
    slot_drive = 1'b0;
    if (bit_cnt == ACK_SLOT)
      slot_drive = ack_go;
    else if (phase == PH_RDATA)
      slot_drive = ~tx_byte[bit_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      after_phase <= PH_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      tx_byte     <= '0;
      ptr         <= '0;
      ptr_ok      <= 1'b0;
      ack_go      <= 1'b0;
      sda_oe      <= 1'b0;
      reg_we      <= 1'b0;
      reg_wdata   <= '0;
    end else begin
      reg_we <= 1'b0;
      if (stop_evt) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        ptr_ok  <= 1'b0;
      end else if (start_evt) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        if (scl_rise && listening) begin
          if (bit_cnt < ACK_SLOT) begin
            bit_cnt <= bit_cnt + 4'd1;
            shreg   <= byte_in;
            if (bit_cnt == LAST_BIT) begin
              ack_go      <= dec_ack;
              after_phase <= dec_next;
              if (dec_latch) begin
                ptr    <= byte_in;
                ptr_ok <= 1'b1;
              end
              if (dec_forget)
                ptr_ok <= 1'b0;
              if (dec_write) begin
                reg_we    <= 1'b1;
                reg_wdata <= byte_in;
              end
            end
          end else begin
            bit_cnt <= '0;
            phase   <= after_phase;
            if (after_phase == PH_RDATA)
              tx_byte <= rd_byte;
          end
        end
        if (scl_fall)
          sda_oe <= slot_drive;
      end
    end
  end

  assign reg_waddr = ptr;

endmodule

// File: rtl/i2c_tgt_regbank.sv
module i2c_tgt_regbank
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]          TGT_ADDR     = 7'h2A,
  parameter int unsigned         NUM_REGS     = 16,
  parameter logic [NUM_REGS-1:0] DEFINED_MASK = 16'hB7DF,
  parameter int unsigned         SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic       scl_lvl;
  logic       sda_lvl;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_evt;
  logic       stop_evt;
  logic       reg_we;
  logic [7:0] reg_waddr;
  logic [7:0] reg_wdata;
  logic [7:0] rd_byte;
  phase_t     phase;
  logic [3:0] bit_cnt;

  i2c_tgt_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2c_tgt_ctrl #(
    .TGT_ADDR    (TGT_ADDR),
    .NUM_REGS    (NUM_REGS),
    .DEFINED_MASK(DEFINED_MASK)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .rd_byte  (rd_byte),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata),
    .phase    (phase),
    .bit_cnt  (bit_cnt)
  );

  i2c_tgt_regfile #(
    .NUM_REGS    (NUM_REGS),
    .DEFINED_MASK(DEFINED_MASK)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .waddr(reg_waddr),
    .wdata(reg_wdata),
    .raddr(reg_waddr),
    .rdata(rd_byte)
  );

endmodule

// File: rtl/i2c_tgt_regbank_chk.sv
module i2c_tgt_regbank_chk
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned         NUM_REGS     = 16,
  parameter logic [NUM_REGS-1:0] DEFINED_MASK = '1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       scl_rise,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sda_oe,
  input phase_t     phase,
  input logic [3:0] bit_cnt,
  input logic       reg_we,
  input logic [7:0] reg_waddr
);

  localparam logic [MAP_SPAN-1:0] MASK_EXT = MAP_SPAN'(DEFINED_MASK);

  p_pull_begins_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_lvl));

  p_pull_held_scl_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sda_oe) && $past(scl_lvl) && scl_lvl) |-> sda_oe);

  p_start_clears_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == PH_ADDR) && (bit_cnt == 4'd0));

  p_count_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8);

  p_stop_goes_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (phase == PH_IDLE) && !sda_oe);

  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);

  p_write_defined_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_defined(MASK_EXT, NUM_REGS, reg_waddr));

  p_write_after_eighth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(scl_rise) && ($past(bit_cnt) == 4'd7));

  p_skip_no_new_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !$rose(sda_oe));

endmodule

bind i2c_tgt_regbank i2c_tgt_regbank_chk #(
  .NUM_REGS    (NUM_REGS),
  .DEFINED_MASK(DEFINED_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_lvl  (scl_lvl),
  .scl_rise (scl_rise),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .sda_oe   (sda_oe),
  .phase    (phase),
  .bit_cnt  (bit_cnt),
  .reg_we   (reg_we),
  .reg_waddr(reg_waddr)
);

// File: tb/i2c_tgt_regbank_bench.sv
module i2c_tgt_regbank_bench;

  localparam logic [6:0]  TGT  = 7'h2A;
  localparam int          N    = 16;
  localparam logic [15:0] MASK = 16'hB7DF;
  localparam int          T    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic bus;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [N];

  assign bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_tgt_regbank u_i2c_tgt_regbank (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_m),
    .sda_i (bus),
    .sda_oe(sda_oe)
  );

  function automatic logic exists(input int idx);
    if (idx >= N) return 1'b0;
    return MASK[idx];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gen_start();
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b0; tick(T);
    scl_m = 1'b0; tick(T);
  endtask

  task automatic gen_stop();
    scl_m = 1'b0;
    sda_m = 1'b0; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b1; tick(T);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(T);
    scl_m = 1'b1; tick(2 * T);
    scl_m = 1'b0; tick(T);
  endtask

  task automatic xmit(input logic [7:0] b, output logic acked, output logic steady);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    s1 = bus; tick(T);
    s2 = bus;
    scl_m = 1'b0; tick(T);
    acked  = !s1;
    steady = (s1 == s2);
  endtask

  task automatic recv(input logic nack, output logic [7:0] b, output logic released);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(T);
      scl_m = 1'b1; tick(T);
      b[i] = bus; tick(T);
      scl_m = 1'b0; tick(T);
    end
    sda_m = nack; tick(T);
    scl_m = 1'b1; tick(T);
    released = bus; tick(T);
    scl_m = 1'b0; tick(T);
    sda_m = 1'b1;
  endtask

  task automatic rd_reg(input int idx);
    logic a, s, r;
    logic [7:0] d;
    gen_start();
    xmit({TGT, 1'b0}, a, s); chk("R3 addr ack (read setup)", int'(a), 1);
    xmit(8'(idx), a, s);     chk("R4 index ack on read", int'(a), int'(exists(idx)));
    gen_start();
    xmit({TGT, 1'b1}, a, s);
    if (exists(idx)) begin
      chk("R6 read addr ack", int'(a), 1);
      chk("R8 ack held through high", int'(s), 1);
      recv(1'b1, d, r);
      chk("R6 read data", int'(d), int'(model[idx]));
      chk("R7 released for final ack", int'(r), 1);
    end else begin
      chk("R6 read addr nack without index", int'(a), 0);
    end
    gen_stop();
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] val);
    logic a, s;
    gen_start();
    xmit({TGT, 1'b0}, a, s); chk("R3 addr ack (write)", int'(a), 1);
    chk("R8 addr ack steady", int'(s), 1);
    xmit(8'(idx), a, s);     chk("R4 index ack on write", int'(a), int'(exists(idx)));
    xmit(val, a, s);         chk("R5 data ack", int'(a), int'(exists(idx)));
    gen_stop();
    if (exists(idx)) model[idx] = val;
  endtask

  initial begin
    logic a, s, r;
    logic [7:0] d;
    logic [7:0] acc;
    acc = 8'd90;
    for (int i = 0; i < N; i++) begin
      model[i] = acc;
      acc = acc + 8'd37;
    end
    tick(5);
    chk("R9 released in reset", int'(bus), 1);
    rst_n = 1'b1;
    tick(5);
    chk("R9 released after reset", int'(bus), 1);

    // R9 / R4 / R6: reset contents and map, indices just past the bank too
    for (int i = 0; i < N + 2; i++) rd_reg(i);

    // R5 / R4: write every index, undefined ones must be refused
    for (int i = 0; i < N + 2; i++) wr_reg(i, 8'((i * 29 + 3) ^ 8'hA5));
    for (int i = 0; i < N + 2; i++) rd_reg(i);

    // R3: each corrupted address bit, both directions
    for (int k = 0; k < 7; k++) begin
      gen_start();
      xmit({TGT ^ 7'(1 << k), 1'b0}, a, s); chk("R3 mismatch nack", int'(a), 0);
      xmit(8'h00, a, s);                    chk("R3 ignored index", int'(a), 0);
      xmit(8'h5C, a, s);                    chk("R3 ignored data", int'(a), 0);
      gen_stop();
      gen_start();
      xmit({TGT ^ 7'(1 << k), 1'b1}, a, s); chk("R3 mismatch read nack", int'(a), 0);
      gen_stop();
    end
    rd_reg(0);

    // R6: read direction with nothing latched
    gen_start();
    xmit({TGT, 1'b1}, a, s); chk("R6 nack without index", int'(a), 0);
    gen_stop();

    // R2: STOP forgets the latched index
    gen_start();
    xmit({TGT, 1'b0}, a, s); xmit(8'd4, a, s); chk("R2 index accepted", int'(a), 1);
    gen_stop();
    gen_start();
    xmit({TGT, 1'b1}, a, s); chk("R2 read after stop nack", int'(a), 0);
    gen_stop();

    // R5: a second data byte is refused and goes nowhere
    gen_start();
    xmit({TGT, 1'b0}, a, s); xmit(8'd1, a, s);
    xmit(8'h3C, a, s); chk("R5 first data ack", int'(a), 1);
    xmit(8'h99, a, s); chk("R5 extra byte nack", int'(a), 0);
    gen_stop();
    model[1] = 8'h3C;
    rd_reg(1);
    rd_reg(2);

    // R4: undefined index stops the write, neighbours unchanged
    gen_start();
    xmit({TGT, 1'b0}, a, s); xmit(8'd11, a, s); chk("R4 undefined nack", int'(a), 0);
    xmit(8'hEE, a, s); chk("R4 data after refusal nack", int'(a), 0);
    gen_stop();
    rd_reg(10);
    rd_reg(12);

    // R7: after the read byte the target stays off the bus
    gen_start();
    xmit({TGT, 1'b0}, a, s); xmit(8'd0, a, s);
    gen_start();
    xmit({TGT, 1'b1}, a, s);
    recv(1'b1, d, r);
    chk("R7 read data", int'(d), int'(model[0]));
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b1; tick(T);
      scl_m = 1'b1; tick(T);
      chk("R7 no drive after nack", int'(bus), 1);
      tick(T);
      scl_m = 1'b0; tick(T);
    end
    gen_stop();

    // R1: repeated START in the middle of a byte restarts reception
    gen_start();
    xmit({TGT, 1'b0}, a, s);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    gen_start();
    xmit({TGT, 1'b0}, a, s); chk("R1 addr after mid-byte start", int'(a), 1);
    xmit(8'd3, a, s);        chk("R1 index after restart", int'(a), 1);
    xmit(8'h77, a, s);       chk("R1 data after restart", int'(a), 1);
    gen_stop();
    model[3] = 8'h77;
    rd_reg(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule